// File: doc/BRIEF.md
# Flash EEPROM Emulation Controller

This block gives a host a small word-addressed store that behaves like an EEPROM. The storage behind it is a data flash with two banks. Flash can be programmed only one page at a time and erased only one whole bank at a time. A register mirror holds the current contents, and host reads are served from it with no flash access. A host write changes one mirror word. The block then programs a complete fresh copy of the mirror into the next region of a ring of four regions, two regions per bank, used in the order 0, 1, 2, 3, 0. Each region is WORDS data pages followed by one marker page. The marker is written last, so a region with no marker is treated as unused.

When a copy lands in the bottom region of a bank, the bank that was just left is erased. The erase command is sent only after the copy and its marker are complete. The erase then runs inside the flash while the other bank stays open to reads and programs. After reset the block reads the marker page of every region and chooses the active region. It loads that region into the mirror before it accepts host writes. If it finds a bank that should have been erased but was not, it erases that bank.

The controller is one state machine. Its states are:
- SCAN: read the marker page of each region.
- PICK: choose the active region.
- LOAD: copy the active region into the mirror.
- IDLE: accept host writes.
- WAITB: wait until the target bank is not erasing.
- PROG: program the data pages.
- MARK: program the marker page.
- ERASE: send the bank erase.

Its transitions are:
- SCAN→PICK after the fourth marker read.
- PICK→LOAD when a marker was found, and PICK→IDLE when none was found.
- LOAD→ERASE when a stale bank exists, and LOAD→IDLE otherwise.
- IDLE→WAITB on an accepted write.
- WAITB→PROG when the target bank is not erasing.
- PROG→MARK after the last data page.
- MARK→ERASE when the target was a bottom region, and MARK→IDLE otherwise.
- ERASE→IDLE on acknowledge.

Top module: `flash_eeprom_emu`

## Requirements
- R1: From reset until the mirror is loaded, `h_busy` is 1. It falls only after 4 marker reads, plus WORDS data reads when a valid region exists.
- R2: At reset the active region is the valid region r whose next region (r+1 mod 4) is not valid. A region is valid when its marker page, at offset WORDS, equals MARK. The mirror then holds that region's data pages.
- R3: When no region holds a marker, region 0 is active and every mirror word reads all-ones.
- R4: A write (`h_we`=1 while `h_busy`=0) updates the mirror word at `h_addr` at that clock edge, and `h_busy` is 1 from the next cycle.
- R5: `h_we` pulses while `h_busy`=1 have no effect on the mirror.
- R6: After an accepted write, the block programs mirror word i at flash address t*(WORDS+1)+i for every i, where t=(active+1) mod 4. It then programs MARK at t*(WORDS+1)+WORDS, and t becomes active.
- R7: When t is even (a bank bottom), an erase of the other bank is sent only after the marker of t has been programmed. Erase addresses are bank bases: 0 for bank 0, 2*(WORDS+1) for bank 1. No erase is sent when t is odd, and the active bank is never erased.
- R8: No read or program goes to a bank whose `fl_bank_busy` bit is set. Commands to the other bank proceed while an erase runs.
- R9: `fl_req` stays high with stable `fl_cmd`, `fl_addr` and `fl_wdata` until `fl_ack`, and is low in the cycle after `fl_ack`. Command codes: read=0, program=1, erase=2.
- R10: At reset, if the bank other than the active one holds any marker, that bank is erased after the mirror load.
- R11: A region whose data pages are programmed but whose marker is absent is treated as unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | $clog2(WORDS) | Host word address |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Mirror word at `h_addr` |
| h_busy | output | 1 | Recovery or copy in progress |
| fl_req | output | 1 | Flash command request |
| fl_cmd | output | 2 | Command code: 0 read, 1 program, 2 erase |
| fl_addr | output | $clog2(4*(WORDS+1)) | Flash page address |
| fl_wdata | output | DW | Program data |
| fl_ack | input | 1 | One-cycle command acknowledge |
| fl_rdata | input | DW | Read data, valid with `fl_ack` |
| fl_bank_busy | input | 2 | Per-bank erase-in-progress flags |

## Verification
Reset recovery is tried with five flash images:
- a blank flash;
- three regions valid after an erase was lost, in both bank orders;
- a region with data but no marker;
- a flash left by earlier traffic.

These separate the "last valid before an invalid" rule from a plain "highest valid" rule, and show whether the stale-bank erase is sent and to which bank. A long run of random writes wraps the ring several times. Each copy is checked page by page, and each erase is checked for its bank and its count, including writes whose target bank is still erasing. Writes held high during a copy show whether busy really stalls the host. A flash model with random latency checks that commands stay stable, that no bank is touched while it erases, and that an erase never runs before the other bank holds a marked copy.

// File: rtl/eee_pkg.sv
package eee_pkg;

    typedef enum logic [1:0] {
        FC_READ  = 2'd0,
        FC_PROG  = 2'd1,
        FC_ERASE = 2'd2
    } fcmd_e;

    typedef enum logic [2:0] {
        S_SCAN,
        S_PICK,
        S_LOAD,
        S_IDLE,
        S_WAITB,
        S_PROG,
        S_MARK,
        S_ERASE
    } st_e;

endpackage

// File: rtl/eee_region_pick.sv
module eee_region_pick (
    input  logic [3:0] vmask,
    output logic       found,
    output logic [1:0] act,
    output logic       stale
);

    always_comb begin
        found = |vmask;
        act   = (&vmask) ? 2'd3 : 2'd0;
        for (int r = 0; r < 4; r++) begin
            if (vmask[r] && !vmask[(r + 1) % 4]) begin
                act = 2'(r);
            end
        end
        stale = found && (act[1] ? (|vmask[1:0]) : (|vmask[3:2]));
    end

    always_comb begin
        if (found) begin
            // R2
            pick_hit_chk: assert (vmask[act]);
        end
    end

endmodule

// File: rtl/eee_mirror.sv
module eee_mirror #(
    parameter int WORDS = 8,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] wa,
    input  logic [DW-1:0]            wd,
    input  logic [$clog2(WORDS)-1:0] ra,
    output logic [DW-1:0]            rda,
    input  logic [$clog2(WORDS)-1:0] rb,
    output logic [DW-1:0]            rdb
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rda = mem[ra];
    assign rdb = mem[rb];

endmodule

// File: rtl/flash_eeprom_emu.sv
module flash_eeprom_emu
    import eee_pkg::*;
#(
    parameter int            WORDS = 8,
    parameter int            DW    = 16,
    parameter logic [DW-1:0] MARK  = DW'('h5AC3)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(WORDS)-1:0]        h_addr,
    input  logic                            h_we,
    input  logic [DW-1:0]                   h_wdata,
    output logic [DW-1:0]                   h_rdata,
    output logic                            h_busy,
    output logic                            fl_req,
    output logic [1:0]                      fl_cmd,
    output logic [$clog2(4*(WORDS+1))-1:0]  fl_addr,
    output logic [DW-1:0]                   fl_wdata,
    input  logic                            fl_ack,
    input  logic [DW-1:0]                   fl_rdata,
    input  logic [1:0]                      fl_bank_busy
);

    localparam int AW  = $clog2(WORDS);
    localparam int RP  = WORDS + 1;
    localparam int FAW = $clog2(4 * RP);
    localparam int CW  = (AW > 2) ? AW : 2;

    function automatic logic [FAW-1:0] rbase(input logic [1:0] r);
        return FAW'(r) * FAW'(RP);
    endfunction

    st_e           state;
    logic [CW-1:0] cnt;
    logic          gap;
    logic [3:0]    vmask;
    logic [1:0]    act;
    logic [1:0]    tgt;
    logic          ebank;
    logic          stale_q;

    logic          pk_found;
    logic [1:0]    pk_act;
    logic          pk_stale;

    logic          mir_we;
    logic [AW-1:0] mir_wa;
    logic [DW-1:0] mir_wd;
    logic [DW-1:0] mir_rdb;
    logic          cnt_last;
    logic          addr_bank;

    assign cnt_last  = (cnt == CW'(WORDS - 1));
    assign addr_bank = (fl_addr >= FAW'(2 * RP));

    eee_region_pick u_pick (
        .vmask (vmask),
        .found (pk_found),
        .act   (pk_act),
        .stale (pk_stale)
    );

    eee_mirror #(.WORDS(WORDS), .DW(DW)) u_mirror (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mir_we),
        .wa    (mir_wa),
        .wd    (mir_wd),
        .ra    (h_addr),
        .rda   (h_rdata),
        .rb    (cnt[AW-1:0]),
        .rdb   (mir_rdb)
    );

    // State register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_SCAN;
            cnt     <= '0;
            gap     <= 1'b0;
            vmask   <= '0;
            act     <= 2'd0;
            tgt     <= 2'd0;
            ebank   <= 1'b0;
            stale_q <= 1'b0;
        end else begin
            gap <= fl_ack;
            unique case (state)
                S_SCAN: if (fl_ack) begin
                    vmask[cnt[1:0]] <= (fl_rdata == MARK);
                    if (cnt[1:0] == 2'd3) begin
                        state <= S_PICK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PICK: begin
                    act     <= pk_act;
                    stale_q <= pk_stale;
                    ebank   <= ~pk_act[1];
                    cnt     <= '0;
                    state   <= pk_found ? S_LOAD : S_IDLE;
                end
                S_LOAD: if (fl_ack) begin
                    if (cnt_last) begin
                        cnt   <= '0;
                        state <= stale_q ? S_ERASE : S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_IDLE: if (h_we) begin
                    tgt   <= act + 2'd1;
                    state <= S_WAITB;
                end
                S_WAITB: if (!fl_bank_busy[tgt[1]]) begin
                    cnt   <= '0;
                    state <= S_PROG;
                end
                S_PROG: if (fl_ack) begin
                    if (cnt_last) begin
                        cnt   <= '0;
                        state <= S_MARK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_MARK: if (fl_ack) begin
                    act <= tgt;
                    if (!tgt[0]) begin
                        ebank <= ~tgt[1];
                        state <= S_ERASE;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_ERASE: if (fl_ack) begin
                    state <= S_IDLE;
                end
                default: state <= S_SCAN;
            endcase
        end
    end

    // Outputs: flash command, mirror write, busy
    always_comb begin
        fl_req   = 1'b0;
        fl_cmd   = FC_READ;
        fl_addr  = '0;
        fl_wdata = '0;
        mir_we   = 1'b0;
        mir_wa   = h_addr;
        mir_wd   = h_wdata;
        h_busy   = 1'b1;
        unique case (state)
            S_SCAN: begin
                fl_req  = !gap;
                fl_addr = rbase(cnt[1:0]) + FAW'(WORDS);
            end
            S_PICK: ;
            S_LOAD: begin
                fl_req  = !gap;
                fl_addr = rbase(act) + FAW'(cnt);
                mir_we  = fl_ack;
                mir_wa  = cnt[AW-1:0];
                mir_wd  = fl_rdata;
            end
            S_IDLE: begin
                h_busy = 1'b0;
                mir_we = h_we;
            end
            S_WAITB: ;
            S_PROG: begin
                fl_req   = !gap;
                fl_cmd   = FC_PROG;
                fl_addr  = rbase(tgt) + FAW'(cnt);
                fl_wdata = mir_rdb;
            end
            S_MARK: begin
                fl_req   = !gap;
                fl_cmd   = FC_PROG;
                fl_addr  = rbase(tgt) + FAW'(WORDS);
                fl_wdata = MARK;
            end
            S_ERASE: begin
                fl_req  = !gap;
                fl_cmd  = FC_ERASE;
                fl_addr = rbase({ebank, 1'b0});
            end
            default: ;
        endcase
    end

    // R9
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_cmd) && $stable(fl_wdata));

    // R9
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ack |=> !fl_req);

    // R8
    bank_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_cmd != FC_ERASE) |-> !fl_bank_busy[addr_bank]);

    // R7
    erase_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_cmd == FC_ERASE) |-> addr_bank != act[1]);

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_we && !h_busy |=> h_busy);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_busy && !fl_ack |=> $stable(h_rdata) || $changed(h_addr));

endmodule

// File: tb/flash_eeprom_emu_test.sv
module flash_eeprom_emu_test;

    localparam int WORDS = 8;
    localparam int DW    = 16;
    localparam int RP    = WORDS + 1;
    localparam int NPG   = 4 * RP;
    localparam logic [15:0] MARKV = 16'h5AC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  h_addr = '0;
    logic        h_we = 1'b0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        h_busy;
    logic        fl_req;
    logic [1:0]  fl_cmd;
    logic [5:0]  fl_addr;
    logic [15:0] fl_wdata;
    logic        fl_ack = 1'b0;
    logic [15:0] fl_rdata = '0;
    logic [1:0]  fl_bank_busy = '0;

    flash_eeprom_emu #(.WORDS(WORDS), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_busy(h_busy), .fl_req(fl_req), .fl_cmd(fl_cmd),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata),
        .fl_bank_busy(fl_bank_busy)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int scenario = 0;

    // ---------------- flash model ----------------
    logic [15:0] fmem [NPG];
    int n_read, n_prog, n_erase, last_eb;
    int prog_viol, rd_viol, hs_viol, order_viol;
    int ecnt [2];
    int lat;
    bit pend;
    logic [5:0]  pa;
    logic [1:0]  pc;
    logic [15:0] pw;

    function automatic logic [15:0] dval(input int r, input int i);
        return {4'(r + 1), 4'h0, 8'(i * 3 + 7)};
    endfunction

    function automatic logic [15:0] fval(input int scn, input int a);
        int r = a / RP;
        int i = a % RP;
        logic [3:0] vm;
        logic [3:0] dm;
        case (scn)
            1: begin vm = 4'b0111; dm = 4'b0111; end
            2: begin vm = 4'b1101; dm = 4'b1101; end
            3: begin vm = 4'b0001; dm = 4'b0011; end
            default: begin vm = 4'b0000; dm = 4'b0000; end
        endcase
        if (scn == 4) return fmem[a];
        if (i == WORDS) return vm[r] ? MARKV : 16'hFFFF;
        return dm[r] ? dval(r, i) : 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            fl_ack <= 1'b0;
            fl_bank_busy <= '0;
            pend = 1'b0;
            lat = 0;
            n_read = 0; n_prog = 0; n_erase = 0; last_eb = -1;
            ecnt[0] = 0; ecnt[1] = 0;
            for (int a = 0; a < NPG; a++) fmem[a] = fval(scenario, a);
        end else begin
            if (fl_ack) begin
                fl_ack <= 1'b0;
            end else if (fl_req) begin
                if (!pend) begin
                    pend = 1'b1;
                    lat = int'($urandom_range(0, 3));
                    pa = fl_addr; pc = fl_cmd; pw = fl_wdata;
                end else if (fl_addr != pa || fl_cmd != pc || fl_wdata != pw) begin
                    hs_viol++;
                end
                if (lat == 0) begin
                    pend = 1'b0;
                    fl_ack <= 1'b1;
                    case (pc)
                        2'd0: begin
                            if (fl_bank_busy[pa >= 6'(2 * RP)]) rd_viol++;
                            fl_rdata <= fmem[pa];
                            n_read++;
                        end
                        2'd1: begin
                            if (fl_bank_busy[pa >= 6'(2 * RP)]) prog_viol++;
                            fmem[pa] = pw;
                            n_prog++;
                        end
                        default: begin
                            automatic int b = (pa >= 6'(2 * RP)) ? 1 : 0;
                            automatic int ob = 1 - b;
                            if (fmem[(2 * ob) * RP + WORDS] != MARKV &&
                                fmem[(2 * ob + 1) * RP + WORDS] != MARKV) order_viol++;
                            fl_bank_busy[b] <= 1'b1;
                            ecnt[b] = 30;
                            n_erase++;
                            last_eb = b;
                        end
                    endcase
                end else begin
                    lat--;
                end
            end
            for (int b = 0; b < 2; b++) begin
                if (fl_bank_busy[b]) begin
                    if (ecnt[b] == 0) begin
                        for (int k = 0; k < 2 * RP; k++) fmem[b * 2 * RP + k] = 16'hFFFF;
                        fl_bank_busy[b] <= 1'b0;
                    end else begin
                        ecnt[b]--;
                    end
                end
            end
        end
    end

    // ---------------- bench helpers ----------------
    logic [15:0] exp_mir [WORDS];
    int exp_act;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        while (h_busy) @(negedge clk);
    endtask

    task automatic check_mirror(input string req);
        for (int a = 0; a < WORDS; a++) begin
            h_addr = 3'(a);
            #1;
            check(h_rdata == exp_mir[a], req, h_rdata, exp_mir[a]);
        end
    endtask

    task automatic do_reset(input int scn, input int exp_reads, input int exp_er, input int exp_b);
        @(negedge clk);
        scenario = scn;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(h_busy == 1'b1, "R1 busy in reset", h_busy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(h_busy == 1'b1, "R1 busy after reset", h_busy, 1);
        wait_idle();
        check(n_read == exp_reads, "R1 reads before idle", n_read, exp_reads);
        check(n_erase == exp_er, "R10 recovery erase count", n_erase, exp_er);
        if (exp_er != 0) check(last_eb == exp_b, "R10 recovery erase bank", last_eb, exp_b);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        int t;
        int ne0;
        bit ok;
        logic [2:0] b;
        logic [15:0] held;
        t = (exp_act + 1) % 4;
        ne0 = n_erase;
        h_addr = a; h_wdata = d; h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
        exp_mir[a] = d;
        #1;
        check(h_busy == 1'b1, "R4 busy after write", h_busy, 1);
        check(h_rdata == d, "R4 mirror updated", h_rdata, d);
        b = a + 3'd1;
        held = exp_mir[b];
        h_addr = b; h_wdata = ~held; h_we = 1'b1;
        repeat (3) @(negedge clk);
        h_we = 1'b0;
        wait_idle();
        h_addr = b;
        #1;
        check(h_rdata == held, "R5 stalled write ignored", h_rdata, held);
        ok = (fmem[t * RP + WORDS] == MARKV);
        for (int i = 0; i < WORDS; i++) if (fmem[t * RP + i] != exp_mir[i]) ok = 0;
        check(ok, "R6 region copy", t, t);
        exp_act = t;
        if (t % 2 == 0) begin
            check(n_erase == ne0 + 1, "R7 erase after bottom copy", n_erase, ne0 + 1);
            check(last_eb == 1 - t / 2, "R7 erased bank", last_eb, 1 - t / 2);
        end else begin
            check(n_erase == ne0, "R7 no erase for top copy", n_erase, ne0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // blank flash: fallback
        for (int i = 0; i < WORDS; i++) exp_mir[i] = 16'hFFFF;
        exp_act = 0;
        do_reset(0, 4, 0, 0);
        check_mirror("R3 blank mirror");
        host_write(3'd2, 16'h1234);
        host_write(3'd7, 16'h0000);
        host_write(3'd0, 16'hFFFE);
        for (int n = 0; n < 40; n++) begin
            host_write(3'($urandom_range(0, 7)), 16'($urandom));
        end
        check_mirror("R4 mirror after random writes");

        // reset keeping flash contents produced above
        exp_act = exp_act;
        do_reset(4, 4 + WORDS, 0, 0);
        check_mirror("R2 recovery of written data");

        // regions 0,1,2 valid: lost erase of bank 0
        for (int i = 0; i < WORDS; i++) exp_mir[i] = dval(2, i);
        exp_act = 2;
        do_reset(1, 4 + WORDS, 1, 0);
        check_mirror("R2 active region 2");
        host_write(3'd5, 16'hA001);
        host_write(3'd1, 16'hA002);
        host_write(3'd3, 16'hA003);

        // regions 2,3,0 valid: active 0, stale bank 1
        for (int i = 0; i < WORDS; i++) exp_mir[i] = dval(0, i);
        exp_act = 0;
        do_reset(2, 4 + WORDS, 1, 1);
        check_mirror("R2 wrapped active region 0");
        host_write(3'd4, 16'hB004);
        host_write(3'd6, 16'hB006);

        // region 1 data without marker
        for (int i = 0; i < WORDS; i++) exp_mir[i] = dval(0, i);
        exp_act = 0;
        do_reset(3, 4 + WORDS, 0, 0);
        check_mirror("R11 unmarked region ignored");
        host_write(3'd0, 16'hC000);

        check(prog_viol == 0 && rd_viol == 0, "R8 no access to erasing bank", prog_viol + rd_viol, 0);
        check(hs_viol == 0, "R9 request stable until ack", hs_viol, 0);
        check(order_viol == 0, "R7 copy before erase", order_viol, 0);
        check(n_prog > 0, "R6 programs issued", n_prog, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule